// File: doc/BRIEF.md
# Salsa20 Core Permutation Engine

The block computes the Salsa20 core function over a 512-bit block of sixteen 32-bit words. A one-cycle start pulse captures the input block and a round count. The engine then iterates and returns the output block together with a one-cycle done pulse. The output block is the permuted state added word by word to the captured input, modulo 2^32.

Internally the state is held as four diagonal vectors of four lanes each. Lane i of vector k holds word (4k+5i) mod 16. With this layout, four quarter-rounds run side by side on every clock. A column pass feeds the vectors straight into the lanes. A row pass feeds them after rotating vectors 1, 2 and 3 by 1, 2 and 3 lanes, and writes the results back through the inverse rotations. Each clock performs one pass, so each clock is half of a double round.

Top module: `salsa_core`

## Requirements
- R1: After reset, out_block_o is all zeros and busy_o and done_o are low.
- R2: With rounds_i = 20, out_block_o equals the Salsa20/20 core of the captured block. Words are little-endian in the vector, with word 0 in bits 31:0. Each quarter-round on (a,b,c,d) updates b, c, d and a in that order, using left rotations of 7, 9, 13 and 18 applied to the sums a+d, a+b, b+c and c+d.
- R3: Any other even nonzero rounds_i (for example 8 or 12) applies that many rounds, alternating a column pass and a row pass and starting with a column pass.
- R4: rounds_i = 0 gives each output word equal to twice the input word, modulo 2^32.
- R5: done_o is high for exactly one cycle, rounds_i + 1 clock edges after the edge that accepts start_i.
- R6: busy_o is high from the edge after start_i is accepted until the done cycle, and it is low in the done cycle.
- R7: A start_i pulse while busy_o is high is ignored: the running job's result and latency do not change.
- R8: in_block_i is sampled only at acceptance. Changing it while busy has no effect on the result.
- R9: out_block_o holds its value between done pulses.
- R10: An all-zero input block gives an all-zero output block for any round count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when not busy |
| rounds_i | input | ROUND_W (5) | Round count, even |
| in_block_i | input | 512 | Input block, word 0 in bits 31:0 |
| out_block_o | output | 512 | Result block, held until the next done |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that rounds_i is even and that start_i is only meaningful as a single-cycle request. An odd count would silently round up to the next double round. The stimulus uses only counts of 0, 8, 12 and 20. It raises start_i for one cycle per job, except for the deliberate extra pulse that tests the busy guard, and it never asserts reset in the middle of a job.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int NWORDS  = LANES * LANES;
  localparam int BLK_W   = NWORDS * WORD_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int ROT_B   = 7;
  localparam int ROT_C   = 9;
  localparam int ROT_D   = 13;
  localparam int ROT_A   = 18;

  typedef logic [WORD_W-1:0]          word_t;
  typedef logic [LANES-1:0][WORD_W-1:0] vec_t;
  typedef logic [LANES-1:0][LANES-1:0][WORD_W-1:0] diag_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] blk_t;

  // lane i of vector k <- word (4k + 5i) mod 16
  function automatic int diag_idx(int k, int i);
    return (LANES * k + (LANES + 1) * i) % NWORDS;
  endfunction

  function automatic diag_t to_diag(blk_t b);
    diag_t d;
    for (int k = 0; k < LANES; k++)
      for (int i = 0; i < LANES; i++)
        d[k][i] = b[diag_idx(k, i)];
    return d;
  endfunction

  function automatic blk_t from_diag(diag_t d);
    blk_t b;
    b = '0;
    for (int k = 0; k < LANES; k++)
      for (int i = 0; i < LANES; i++)
        b[diag_idx(k, i)] = d[k][i];
    return b;
  endfunction
endpackage

// File: rtl/salsa_qr.sv
module salsa_qr
  import salsa_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  function automatic word_t rotl(word_t v, int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  word_t b1, c1, d1;

  // sequential dependency: each update uses the freshly updated words
  assign b1  = b_i ^ rotl(a_i + d_i, ROT_B);
  assign c1  = c_i ^ rotl(a_i + b1,  ROT_C);
  assign d1  = d_i ^ rotl(b1 + c1,   ROT_D);
  assign a_o = a_i ^ rotl(c1 + d1,   ROT_A);
  assign b_o = b1;
  assign c_o = c1;
  assign d_o = d1;
endmodule

// File: rtl/salsa_half.sv
module salsa_half
  import salsa_pkg::*;
(
  input  diag_t st_i,
  input  logic  row_pass_i,
  output diag_t st_o
);
  vec_t qa, qb, qc, qd, oa, ob, oc, od;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int J1 = (j + 1) % LANES;
    localparam int J2 = (j + 2) % LANES;
    localparam int J3 = (j + 3) % LANES;
    // row pass: V3 rot 3, V2 rot 2, V1 rot 1, argument order (V0,V3,V2,V1)
    assign qa[j] = st_i[0][j];
    assign qb[j] = row_pass_i ? st_i[3][J1] : st_i[1][j];
    assign qc[j] = row_pass_i ? st_i[2][J2] : st_i[2][j];
    assign qd[j] = row_pass_i ? st_i[1][J3] : st_i[3][j];

    salsa_qr u_qr (
      .a_i(qa[j]), .b_i(qb[j]), .c_i(qc[j]), .d_i(qd[j]),
      .a_o(oa[j]), .b_o(ob[j]), .c_o(oc[j]), .d_o(od[j])
    );
  end

  // inverse rotation on write-back
  always_comb begin
    st_o = '0;
    for (int j = 0; j < LANES; j++) begin
      st_o[0][j] = oa[j];
      if (row_pass_i) begin
        st_o[3][LANE_W'(j + 1)] = ob[j];
        st_o[2][LANE_W'(j + 2)] = oc[j];
        st_o[1][LANE_W'(j + 3)] = od[j];
      end else begin
        st_o[1][j] = ob[j];
        st_o[2][j] = oc[j];
        st_o[3][j] = od[j];
      end
    end
  end
endmodule

// File: rtl/salsa_ctrl.sv
module salsa_ctrl #(
  parameter int ROUND_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ROUND_W-1:0] rounds_i,
  output logic               load_o,
  output logic               step_o,
  output logic               row_pass_o,
  output logic               fin_o,
  output logic               busy_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrl_st_e;

  ctrl_st_e           st_q;
  logic [ROUND_W-1:0] left_q;
  logic               half_q;

  assign load_o     = (st_q == ST_IDLE) && start_i;
  assign step_o     = (st_q == ST_RUN);
  assign row_pass_o = half_q;
  assign fin_o      = (st_q == ST_FIN);
  assign busy_o     = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      half_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          left_q <= rounds_i;
          half_q <= 1'b0;
          st_q   <= (rounds_i == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          half_q <= ~half_q;
          if (half_q) begin
            left_q <= left_q - ROUND_W'(2);
            if (left_q <= ROUND_W'(2)) st_q <= ST_FIN;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_RUN_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> left_q != '0);  // R5
  AST_ZERO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && rounds_i == '0) |=> st_q == ST_FIN);  // R4
endmodule

// File: rtl/salsa_core.sv
module salsa_core
  import salsa_pkg::*;
#(
  parameter int ROUND_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ROUND_W-1:0] rounds_i,
  input  logic [BLK_W-1:0]   in_block_i,
  output logic [BLK_W-1:0]   out_block_o,
  output logic               busy_o,
  output logic               done_o
);
  logic  load, step, row_pass, fin;
  diag_t st_q, st_nxt;
  blk_t  orig_q, out_q, back, sum;

  salsa_ctrl #(.ROUND_W(ROUND_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .rounds_i,
    .load_o(load), .step_o(step), .row_pass_o(row_pass),
    .fin_o(fin), .busy_o(busy_o)
  );

  salsa_half u_half (.st_i(st_q), .row_pass_i(row_pass), .st_o(st_nxt));

  assign back = from_diag(st_q);
  for (genvar w = 0; w < NWORDS; w++) begin : g_ff
    assign sum[w] = back[w] + orig_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      orig_q <= '0;
      out_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin;
      if (load) begin
        st_q   <= to_diag(blk_t'(in_block_i));
        orig_q <= blk_t'(in_block_i);
      end else if (step) begin
        st_q <= st_nxt;
      end
      if (fin) out_q <= sum;
    end
  end

  assign out_block_o = BLK_W'(out_q);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R6
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);  // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(orig_q));  // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(out_block_o));  // R9
endmodule

// File: tb/test_salsa_core.sv
`timescale 1ns/1ps
module test_salsa_core;
  typedef logic [15:0][31:0] st_t;
  typedef struct packed {
    logic [31:0] seed;
    logic [4:0]  rnds;
    logic [1:0]  mode;  // 0 plain, 1 change input mid-run, 2 extra start mid-run
  } vec_e;

  localparam int NV = 7;
  localparam vec_e TBL [NV] = '{
    '{32'h0000_0001, 5'd20, 2'd0},
    '{32'hdead_beef, 5'd20, 2'd0},
    '{32'h1234_5678, 5'd8,  2'd0},
    '{32'h8765_4321, 5'd12, 2'd0},
    '{32'h0bad_cafe, 5'd0,  2'd0},
    '{32'h5555_aaaa, 5'd20, 2'd1},
    '{32'hface_0ff0, 5'd12, 2'd2}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] rounds = '0;
  logic [511:0] in_blk = '0;
  logic [511:0] out_blk;
  logic busy, done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  salsa_core i_salsa_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rounds_i(rounds),
    .in_block_i(in_blk), .out_block_o(out_blk), .busy_o(busy), .done_o(done)
  );

  function automatic logic [31:0] rl(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic st_t qr(st_t x, int a, int b, int c, int d);
    x[b] ^= rl(x[a] + x[d], 7);
    x[c] ^= rl(x[b] + x[a], 9);
    x[d] ^= rl(x[c] + x[b], 13);
    x[a] ^= rl(x[d] + x[c], 18);
    return x;
  endfunction

  function automatic logic [511:0] ref_core(logic [511:0] blk, int rnds);
    st_t x, o;
    x = blk;
    for (int r = rnds; r > 0; r -= 2) begin
      x = qr(x, 0, 4, 8, 12);  x = qr(x, 5, 9, 13, 1);
      x = qr(x, 10, 14, 2, 6); x = qr(x, 15, 3, 7, 11);
      x = qr(x, 0, 1, 2, 3);   x = qr(x, 5, 6, 7, 4);
      x = qr(x, 10, 11, 8, 9); x = qr(x, 15, 12, 13, 14);
    end
    for (int w = 0; w < 16; w++) o[w] = x[w] + blk[32*w +: 32];
    return o;
  endfunction

  function automatic logic [511:0] mk_blk(logic [31:0] seed);
    logic [511:0] b;
    for (int w = 0; w < 16; w++)
      b[32*w +: 32] = rl(seed, w) ^ (32'h9e37_79b9 * (w + 1));
    return b;
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_job(logic [511:0] blk, logic [4:0] rn, int mode,
                         output logic [511:0] got, output int lat, output bit busy_ok);
    @(negedge clk);
    in_blk = blk; rounds = rn; start = 1;
    lat = 0; busy_ok = 1;
    while (1) begin
      @(negedge clk);
      lat++;
      if (lat == 1) start = 0;
      if (done) break;
      if (!busy) busy_ok = 0;
      if (lat == 3 && mode == 1) in_blk = ~blk;
      if (lat == 3 && mode == 2) begin in_blk = ~blk; rounds = 5'd0; start = 1; end
      if (lat == 4 && mode == 2) start = 0;
      if (lat > 100) break;
    end
    if (busy) busy_ok = 0;
    got = out_blk;
  endtask

  initial begin
    logic [511:0] got, exp;
    int lat;
    bit bok;
    string tag;
    #12;
    chk(out_blk == '0, "R1", out_blk, '0);
    chk(busy == 0 && done == 0, "R1", {busy, done}, '0);
    rst_n = 1;
    #3;
    chk(out_blk == '0 && !busy && !done, "R1", out_blk, '0);

    for (int v = 0; v < NV; v++) begin
      logic [511:0] blk;
      blk = mk_blk(TBL[v].seed);
      exp = ref_core(blk, int'(TBL[v].rnds));
      tag = TBL[v].mode == 1 ? "R8" : TBL[v].mode == 2 ? "R7" :
            TBL[v].rnds == 0 ? "R4" : TBL[v].rnds == 20 ? "R2" : "R3";
      run_job(blk, TBL[v].rnds, int'(TBL[v].mode), got, lat, bok);
      chk(got == exp, tag, got, exp);
      chk(lat == int'(TBL[v].rnds) + 2, "R5", 512'(lat), 512'(int'(TBL[v].rnds) + 2));
      chk(bok, "R6", 512'(bok), 512'(1));
      @(negedge clk);
      chk(!done, "R5", 512'(done), '0);
    end

    // R4: zero rounds doubles each word, computed directly
    begin
      logic [511:0] blk;
      blk = mk_blk(32'h0f0f_1234);
      for (int w = 0; w < 16; w++) exp[32*w +: 32] = blk[32*w +: 32] + blk[32*w +: 32];
      run_job(blk, 5'd0, 0, got, lat, bok);
      chk(got == exp, "R4", got, exp);
    end

    // R10: all-zero input
    run_job('0, 5'd20, 0, got, lat, bok);
    chk(got == '0, "R10", got, '0);
    run_job('0, 5'd8, 0, got, lat, bok);
    chk(got == '0, "R10", got, '0);

    // R9: result held after done while inputs wander
    exp = ref_core(mk_blk(32'h0000_00aa), 12);
    run_job(mk_blk(32'h0000_00aa), 5'd12, 0, got, lat, bok);
    in_blk = '1;
    repeat (6) @(negedge clk);
    chk(out_blk == exp, "R9", out_blk, exp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule